// File: doc/BRIEF.md
# Interval Event Statistics Unit with Register Access and Capture Queue

This block measures how often an event occurs. On every clock an external source presents the number of events seen in that cycle, from zero up to a configurable ceiling. Software programs an interval length in clock cycles. The block then adds up events over consecutive intervals of that length. At the end of each interval it latches the cycle count and the event total into result registers, clears its accumulators and starts the next interval at once. The result registers therefore keep changing while software watches them.

Polling the result registers will miss intervals, so an optional capture queue can record consecutive interval totals. While software keeps capture switched on, every completed interval total is pushed into the queue. Afterwards software reads the queue head together with its valid flag, pops it by writing to the same address, and repeats until the flag drops.

All access goes through a simple register port. It has read and write strobes, an address, write data, registered read data with a read-valid pulse, and an accept signal. The accept signal is held high, so the port never applies back-pressure and every strobe takes effect in the cycle it is presented.

Top module: `evtstat_regif`

## Requirements
- R1: After reset the counter is stopped (interval length 0), both result registers and the capture-enable bit read 0, the queue is empty, and no read-valid pulse is present.
- R2: A write of N to the interval address discards any partial interval and restarts counting. Each completed run of N cycles then sets the cycle-count result to N and the event result to the sum of the per-cycle event inputs over those cycles. The first run begins in the cycle after the write, and counting continues without gaps. Writing 0 stops counting, and the results hold. Per-cycle inputs up to 2^EVT_W-1 are summed without loss.
- R3: A read strobe returns data on the next cycle with read-valid high for that one cycle. The interval address reads the last completed cycle count and the events address reads the last completed event total, both zero-extended. The accept output is always 1.
- R4: Only address bits set in ADDR_MASK are compared during decoding, so addresses that differ only in masked-off bits alias to the same register. A read that hits no register returns 0, and a write that hits no register changes nothing.
- R5: A write to the capture-enable address stores write-data bit 0, and reading that address returns the stored bit in bit 0.
- R6: While capture is enabled, the event total of every completed interval is pushed into the queue. While it is disabled, nothing is pushed.
- R7: A read of the queue address returns the head entry in the low bits and a valid flag in bit DATA_W-1. When the queue is empty the whole word is 0.
- R8: Any write to the queue address removes exactly one entry. A write to that address while the queue is empty has no effect.
- R9: When the queue is full, new interval totals are dropped, and the stored entries are kept in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_num_i | input | EVT_W | Number of events in the current cycle |
| reg_addr_i | input | DATA_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | DATA_W | Read data, valid one cycle after the read strobe |
| reg_rvld_o | output | 1 | Read data valid |
| reg_ardy_o | output | 1 | Access accepted (held at 1) |

## Verification
The hardest state to reach from the ports is a full queue that keeps receiving interval totals that must be dropped, followed by a drain whose order must still match arrival. The bench shrinks the queue depth and uses short intervals. It then leaves capture enabled across many more intervals than the queue can hold and drains it with read-then-pop pairs. A run with a varying event pattern makes every entry distinct, and a reference model built from queues checks each read word on every clock.

// File: rtl/evtstat_pkg.sv
package evtstat_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IVL,
    SEL_EVT,
    SEL_CAP,
    SEL_FIFO
  } regsel_e;
endpackage

// File: rtl/evtstat_decode.sv
module evtstat_decode
  import evtstat_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] IVL_ADR  = AW'(0),
  parameter logic [AW-1:0] EVT_ADR  = AW'(1),
  parameter logic [AW-1:0] CAP_ADR  = AW'(2),
  parameter logic [AW-1:0] FIFO_ADR = AW'(3),
  parameter logic [AW-1:0] ADDR_MASK = '1
) (
  input  logic [AW-1:0] addr_i,
  output regsel_e       sel_o
);
  localparam int unsigned NREG = 4;
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    localparam logic [AW-1:0] BASE = (g == 0) ? IVL_ADR :
                                     (g == 1) ? EVT_ADR :
                                     (g == 2) ? CAP_ADR : FIFO_ADR;
    assign hit[g] = ((addr_i ^ BASE) & ADDR_MASK) == '0;
  end

  always_comb begin
    sel_o = SEL_NONE;
    if (hit[0])      sel_o = SEL_IVL;
    else if (hit[1]) sel_o = SEL_EVT;
    else if (hit[2]) sel_o = SEL_CAP;
    else if (hit[3]) sel_o = SEL_FIFO;
  end
endmodule

// File: rtl/evtstat_core.sv
module evtstat_core #(
  parameter int unsigned CYC_W = 12,
  parameter int unsigned EVT_W = 3,
  localparam int unsigned ACC_W = CYC_W + EVT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we_i,
  input  logic [CYC_W-1:0] cfg_len_i,
  input  logic [EVT_W-1:0] evt_num_i,
  output logic             done_o,
  output logic [ACC_W-1:0] sum_o,
  output logic [CYC_W-1:0] res_cyc_o,
  output logic [ACC_W-1:0] res_evt_o
);
  logic [CYC_W-1:0] len_q;
  logic [CYC_W-1:0] cyc_q;
  logic [ACC_W-1:0] acc_q;
  logic             running;
  logic             last;

  assign running = (len_q != '0);
  assign last    = running && (cyc_q == len_q - 1'b1);
  assign sum_o   = acc_q + ACC_W'(evt_num_i);
  assign done_o  = last && !cfg_we_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q     <= '0;
      cyc_q     <= '0;
      acc_q     <= '0;
      res_cyc_o <= '0;
      res_evt_o <= '0;
    end else if (cfg_we_i) begin
      len_q <= cfg_len_i;
      cyc_q <= '0;
      acc_q <= '0;
    end else if (running) begin
      if (last) begin
        cyc_q     <= '0;
        acc_q     <= '0;
        res_cyc_o <= len_q;
        res_evt_o <= sum_o;
      end else begin
        cyc_q <= cyc_q + 1'b1;
        acc_q <= sum_o;
      end
    end
  end

  // R2
  cyc_range_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> (cyc_q < len_q));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && !cfg_we_i) |=> ($stable(res_evt_o) && $stable(res_cyc_o)));
  // R2
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we_i |=> (cyc_q == '0 && acc_q == '0));
endmodule

// File: rtl/evtstat_fifo.sv
module evtstat_fifo #(
  parameter int unsigned W     = 15,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_en;
  logic             rd_en;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign wr_en   = push_i && !full_o;
  assign rd_en   = pop_i && !empty_o;
  assign head_o  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));
  // R9
  full_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(head_o)));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/evtstat_regif.sv
module evtstat_regif
  import evtstat_pkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned MAX_INTERVAL  = 4095,
  parameter int unsigned MAX_PER_CYCLE = 4,
  parameter bit          CAPTURE_ON    = 1'b1,
  parameter int unsigned FIFO_DEPTH    = 1024,
  parameter logic [DATA_W-1:0] IVL_ADR   = DATA_W'(0),
  parameter logic [DATA_W-1:0] EVT_ADR   = DATA_W'(1),
  parameter logic [DATA_W-1:0] CAP_ADR   = DATA_W'(2),
  parameter logic [DATA_W-1:0] FIFO_ADR  = DATA_W'(3),
  parameter logic [DATA_W-1:0] ADDR_MASK = '1,
  localparam int unsigned CYC_W = $clog2(MAX_INTERVAL + 1),
  localparam int unsigned EVT_W = $clog2(MAX_PER_CYCLE + 1),
  localparam int unsigned ACC_W = CYC_W + EVT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  evt_num_i,
  input  logic [DATA_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_rvld_o,
  output logic              reg_ardy_o
);
  regsel_e          sel;
  logic             wr_ivl;
  logic             wr_cap;
  logic             wr_fifo;
  logic             done;
  logic [ACC_W-1:0] sum;
  logic [CYC_W-1:0] res_cyc;
  logic [ACC_W-1:0] res_evt;
  logic             capen_q;
  logic             fifo_vld;
  logic [ACC_W-1:0] fifo_head;
  logic [DATA_W-1:0] rd_mux;

  assign reg_ardy_o = 1'b1;

  evtstat_decode #(
    .AW(DATA_W), .IVL_ADR(IVL_ADR), .EVT_ADR(EVT_ADR),
    .CAP_ADR(CAP_ADR), .FIFO_ADR(FIFO_ADR), .ADDR_MASK(ADDR_MASK)
  ) decode_i (
    .addr_i(reg_addr_i),
    .sel_o (sel)
  );

  assign wr_ivl  = reg_wr_i && (sel == SEL_IVL);
  assign wr_cap  = reg_wr_i && (sel == SEL_CAP);
  assign wr_fifo = reg_wr_i && (sel == SEL_FIFO);

  evtstat_core #(.CYC_W(CYC_W), .EVT_W(EVT_W)) core_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_we_i (wr_ivl),
    .cfg_len_i(reg_wdata_i[CYC_W-1:0]),
    .evt_num_i(evt_num_i),
    .done_o   (done),
    .sum_o    (sum),
    .res_cyc_o(res_cyc),
    .res_evt_o(res_evt)
  );

  if (CAPTURE_ON) begin : g_capture
    logic fifo_empty;
    logic fifo_full;

    always_ff @(posedge clk) begin
      if (rst)         capen_q <= 1'b0;
      else if (wr_cap) capen_q <= reg_wdata_i[0];
    end

    evtstat_fifo #(.W(ACC_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk    (clk),
      .rst    (rst),
      .push_i (done && capen_q),
      .data_i (sum),
      .pop_i  (wr_fifo),
      .head_o (fifo_head),
      .empty_o(fifo_empty),
      .full_o (fifo_full)
    );
    assign fifo_vld = !fifo_empty;

    // R6
    cap_off_chk: assert property (@(posedge clk) disable iff (rst)
      (!capen_q && !wr_fifo && fifo_empty) |=> fifo_empty);
  end else begin : g_no_capture
    assign capen_q   = 1'b0;
    assign fifo_vld  = 1'b0;
    assign fifo_head = '0;
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_IVL:  rd_mux = DATA_W'(res_cyc);
      SEL_EVT:  rd_mux = DATA_W'(res_evt);
      SEL_CAP:  rd_mux = DATA_W'(capen_q);
      SEL_FIFO: if (fifo_vld) begin
                  rd_mux = DATA_W'(fifo_head);
                  rd_mux[DATA_W-1] = 1'b1;
                end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvld_o  <= 1'b0;
      reg_rdata_o <= '0;
    end else begin
      reg_rvld_o  <= reg_rd_i;
      reg_rdata_o <= reg_rd_i ? rd_mux : '0;
    end
  end

  // R3
  rvld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd_i |=> reg_rvld_o);
  // R3
  rvld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_i |=> !reg_rvld_o);
  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && sel == SEL_FIFO && !fifo_vld) |=> (reg_rdata_o == '0));
  // R4
  miss_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && sel == SEL_NONE) |=> (reg_rdata_o == '0));
endmodule

// File: tb/evtstat_regif_tb.sv
module evtstat_regif_tb_top;
  localparam int DW = 32;
  localparam int DEPTH = 8;
  localparam logic [DW-1:0] MASK = 32'h0000_00FF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    evt = '0;
  logic [DW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [DW-1:0] rdata;
  logic          rvld;
  logic          ardy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  evtstat_regif #(.FIFO_DEPTH(DEPTH), .ADDR_MASK(MASK)) dut_i (
    .clk(clk), .rst(rst), .evt_num_i(evt),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_rdata_o(rdata), .reg_rvld_o(rvld), .reg_ardy_o(ardy)
  );

  // event source
  int evt_mode = 0;
  int evt_const = 0;
  int tick = 0;
  always @(negedge clk) begin
    tick++;
    evt <= 3'((evt_mode != 0) ? ((tick * 3 + 1) % 5) : evt_const);
  end

  // reference model
  int m_len, m_cyc, m_acc, m_rc, m_re, m_cap;
  int q[$];
  bit m_rvld;
  logic [DW-1:0] m_rdata;
  string m_tag = "R3";

  function automatic int sel_of(input logic [DW-1:0] a);
    for (int k = 0; k < 4; k++)
      if (((a ^ DW'(k)) & MASK) == '0) return k + 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_len = 0; m_cyc = 0; m_acc = 0; m_rc = 0; m_re = 0; m_cap = 0;
      q.delete(); m_rvld = 0; m_rdata = '0;
    end else begin
      int s;
      int sz;
      bit done;
      logic [DW-1:0] rv;
      s = sel_of(addr);
      rv = '0;
      case (s)
        1: rv = DW'(m_rc);
        2: rv = DW'(m_re);
        3: rv = DW'(m_cap);
        4: if (q.size() > 0) rv = {1'b1, 31'(q[0])};
        default: rv = '0;
      endcase
      m_rvld = rd;
      m_rdata = rd ? rv : '0;
      if (rd) m_tag = (s == 0) ? "R4" : (s == 1) ? "R3" : (s == 2) ? "R2" :
                      (s == 3) ? "R5" : "R7";
      done = 0;
      if (wr && s == 1) begin
        m_len = int'(wdata & 32'hFFF); m_cyc = 0; m_acc = 0;
      end else if (m_len != 0) begin
        if (m_cyc == m_len - 1) begin
          m_rc = m_len; m_re = m_acc + int'(evt); done = 1;
          m_cyc = 0; m_acc = 0;
        end else begin
          m_cyc++; m_acc += int'(evt);
        end
      end
      sz = q.size();
      if (wr && s == 4 && sz > 0) void'(q.pop_front());
      if (done && m_cap != 0 && sz < DEPTH) q.push_back(m_re);
      if (wr && s == 3) m_cap = int'(wdata[0]);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (rvld !== m_rvld || rdata !== m_rdata) begin
        failures++;
        $display("FAIL %s model: rvld=%b rdata=%h expected rvld=%b rdata=%h",
                 m_tag, rvld, rdata, m_rvld, m_rdata);
      end
      checks++;
      if (ardy !== 1'b1) begin
        failures++;
        $display("FAIL R3 ardy actual=%b expected=1", ardy);
      end
    end
  end

  task automatic do_wr(input logic [DW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic do_rd(input logic [DW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; addr = '0;
    checks++;
    if (rdata !== exp || rvld !== 1'b1) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h vld=%b expected=%h", tag, a, rdata, rvld, exp);
    end
  endtask

  task automatic do_rd_model(input logic [DW-1:0] a);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; addr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      cnt++;
      if (cnt > 100000 && !finished) begin
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    idle(4);
    @(negedge clk); rst = 1'b0;
    checks++;
    if (rvld !== 1'b0) begin
      failures++;
      $display("FAIL R1 rvld actual=%b expected=0", rvld);
    end
    // R1 reset state
    do_rd(32'h0, 32'h0, "R1");
    do_rd(32'h1, 32'h0, "R1");
    do_rd(32'h2, 32'h0, "R1");
    do_rd(32'h3, 32'h0, "R1");

    // R2 constant events, interval 5
    evt_const = 3;
    do_wr(32'h0, 32'd5);
    idle(6);
    do_rd(32'h0, 32'd5, "R2");
    do_rd(32'h1, 32'd15, "R2");
    // R4 aliasing and misses
    do_rd(32'h100, 32'd5, "R4");
    do_rd(32'h55, 32'h0, "R4");
    do_wr(32'h55, 32'h3);
    do_rd(32'h2, 32'h0, "R4");
    do_rd(32'h0, 32'd5, "R4");

    // R2 stop holds results
    do_wr(32'h0, 32'h0);
    evt_const = 4;
    idle(20);
    do_rd(32'h1, 32'd15, "R2");

    // R2 maximum per-cycle value
    evt_const = 7;
    do_wr(32'h0, 32'd10);
    idle(12);
    do_rd(32'h1, 32'd70, "R2");

    // R5 capture-enable readback
    do_wr(32'h2, 32'h1);
    do_rd(32'h2, 32'h1, "R5");
    do_wr(32'h2, 32'h0);
    do_rd(32'h2, 32'h0, "R5");

    // R8 pop on empty queue
    do_wr(32'h3, 32'h0);
    do_rd(32'h3, 32'h0, "R8");

    // R6 nothing captured while disabled
    evt_const = 2;
    do_wr(32'h0, 32'd4);
    idle(20);
    do_rd(32'h3, 32'h0, "R6");

    // R9 overfill, then drain
    do_wr(32'h2, 32'h1);
    idle(60);
    do_wr(32'h2, 32'h0);
    for (int i = 0; i < DEPTH; i++) begin
      do_rd(32'h3, 32'h8000_0008, "R9");
      do_wr(32'h3, 32'h0);
    end
    do_rd(32'h3, 32'h0, "R9");

    // R6/R7/R9 varying pattern, order checked by the model
    evt_mode = 1;
    do_wr(32'h0, 32'd3);
    idle(7);
    do_rd_model(32'h1);
    do_wr(32'h2, 32'h1);
    idle(40);
    do_wr(32'h2, 32'h0);
    for (int i = 0; i < DEPTH + 1; i++) begin
      do_rd_model(32'h3);
      do_wr(32'h3, 32'h0);
    end
    do_rd(32'h3, 32'h0, "R7");

    // R6 short capture window, single pops
    do_wr(32'h2, 32'h1);
    idle(5);
    do_wr(32'h2, 32'h0);
    idle(10);
    for (int i = 0; i < 3; i++) begin
      do_rd_model(32'h3);
      do_wr(32'h3, 32'h0);
    end
    do_rd(32'h3, 32'h0, "R8");

    idle(3);
    finish_run();
  end
endmodule